// File: doc/BRIEF.md
# Private L1 Line Coherence Controller

The block keeps the coherence state of each line of a small, directly indexed private L1 cache that works under a directory-based MESI protocol with a shared L2. One decoded event is applied to one line per cycle. Events are processor loads, instruction fetches, stores, victim evictions, invalidations, forwarded reads, writes and fetches from other caches, data and exclusive data responses, invalidation acks and writeback acks. The event's line index is supplied by the caller, and victim choice is made outside the block. For each event the block decides the next state of that line. It also emits the coherence traffic the event calls for and reports hits back to the core.

Each outgoing message kind has its own valid strobe, so one event can raise several of them in the same cycle. Examples are a data copy to the requester together with a copy to the L2, or an ack together with loss of the store-conditional reservation. All strobes are registered and appear one cycle after the event is sampled. A demand event that meets a line with a transaction in flight is refused with a stall strobe and leaves that line untouched. The wake strobe names the line when its transaction ends, so the caller can replay refused events.

A lookup port returns the state, permission and dirty bit of any line without delay.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads state NP with the dirty bit clear, and all output strobes are low. State codes on `look_state` are NP=0, I=1, S=2, E=3, M=4, IS=5, IM=6, SM=7, IS_I=8, M_I=9, SINK=10.
- R2: Event codes on `ev_code` are LOAD=0, FETCH=1, STORE=2, EVICT=3, INV=4, FWD_RD=5, FWD_WR=6, FWD_FETCH=7, DATA=8, DATA_X=9, ACK=10, WB_ACK=11. Request kinds on `req_kind` are GETS=0, GET_INSTR=1, GETX=2, UPGRADE=3, PUTX=4. Misses from NP or I behave as follows: a load issues GETS and enters IS, a fetch issues GET_INSTR and enters IS, and a store issues GETX and enters IM. A store in S issues UPGRADE and enters SM.
- R3: A LOAD, FETCH, STORE or EVICT to a line in IS, IM, SM, IS_I, M_I or SINK raises only `stall` and leaves that line's state unchanged.
- R4: DATA in IS ends in S, and DATA in IS_I ends in I. Both report the waiting access as a hit and raise a plain `unblock` and `wake`. DATA_X in IS or IS_I ends in E with a hit, `unblock_excl` and `wake`. Hit kinds are LOAD=0, FETCH=1, STORE=2.
- R5: In IM or SM, a DATA adds `ev_acks` to the count of acks still owed, and each ACK removes one. Acks may arrive before the data. The transaction finishes on the event that brings the count to zero, or on DATA_X. On finishing, the line enters M with the dirty bit set and raises a store hit, `unblock_excl` and `wake`.
- R6: A store in E or M is a store hit that leaves the line in M with the dirty bit set. A load or fetch in S, E or M is a hit with no state change.
- R7: EVICT in S goes silently to I, and EVICT in NP or I leaves the line in NP. EVICT in E or M issues PUTX and enters M_I with the dirty bit kept. WB_ACK in M_I raises `wake` and ends in I.
- R8: In M_I, an INV sends data to the L2 and a FWD_WR sends data to the requester, and both enter SINK. In SINK, INV answers with an ack, and WB_ACK raises `wake` and ends in I.
- R9: In E or M, FWD_RD or FWD_FETCH sends data to both the requester and the L2 and ends in S with the dirty bit clear. FWD_WR sends data to the requester only and ends in I.
- R10: INV in IS acknowledges and enters IS_I, and the later DATA is reported as a hit exactly once.
- R11: INV in SM acknowledges, raises `resv_lost` and returns to IM. INV in M sends data to the L2 without an ack. INV in E, S, I or NP acknowledges and leaves the line in I, or in NP for NP.
- R12: `look_perm` reads 0 for NP and I, 1 (read) for S, E and SM, 3 (read-write) for M, and 2 (busy) for every other transient state.
- R13: An event changes only the line it names. Output strobes carry that line on `msg_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_code | input | 4 | Event code (R2) |
| ev_line | input | IDX_W | Line the event applies to |
| ev_acks | input | CNT_W | Acks owed, carried by DATA |
| look_line | input | IDX_W | Line to inspect |
| look_state | output | 4 | State code of the inspected line |
| look_perm | output | 2 | Access permission of the inspected line |
| look_dirty | output | 1 | Dirty bit of the inspected line |
| req_valid | output | 1 | Request to the L2 |
| req_kind | output | 3 | Request kind |
| data_to_req | output | 1 | Data response to the requesting cache |
| data_to_l2 | output | 1 | Data response to the L2 |
| inv_ack | output | 1 | Invalidation ack |
| unblock | output | 1 | Plain unblock to the directory |
| unblock_excl | output | 1 | Exclusive unblock to the directory |
| msg_line | output | IDX_W | Line that the strobes refer to |
| msg_dirty | output | 1 | Dirty bit carried by data or PUTX |
| hit_valid | output | 1 | Access completed to the core |
| hit_kind | output | 2 | Kind of completed access |
| resv_lost | output | 1 | Store-conditional reservation lost |
| wake_valid | output | 1 | Transaction on `msg_line` ended; replay stalled events |
| stall | output | 1 | Event refused, not consumed |

## Verification
The bench aims at the races. An invalidate that overtakes the shared data must end the line in I after exactly one hit; a design that dropped the hit would hang the core, and one that kept the line in S would leave a stale copy. An invalidate during an upgrade must drop the line back to IM and report the lost reservation. Acks that arrive before the data must leave the count negative and finish the transaction on the data; a design that clamped at zero would never leave IM. An invalidate or forwarded write during a writeback must move to SINK and still answer a later invalidate. Misrouted dirty handling shows up as a wrong dirty bit after a forwarded read or a PUTX, and a demand event leaking into a busy line shows up as a state change on a stall cycle.

// File: rtl/mesi_l1_pkg.sv
// Shared encodings for the L1 line coherence controller.
// Assumes: state, event and message codes are fixed by the block's contract.
package mesi_l1_pkg;

    typedef enum logic [3:0] {
        ST_NP   = 4'd0,
        ST_I    = 4'd1,
        ST_S    = 4'd2,
        ST_E    = 4'd3,
        ST_M    = 4'd4,
        ST_IS   = 4'd5,
        ST_IM   = 4'd6,
        ST_SM   = 4'd7,
        ST_IS_I = 4'd8,
        ST_M_I  = 4'd9,
        ST_SINK = 4'd10
    } line_st_e;

    typedef enum logic [3:0] {
        EV_LOAD      = 4'd0,
        EV_FETCH     = 4'd1,
        EV_STORE     = 4'd2,
        EV_EVICT     = 4'd3,
        EV_INV       = 4'd4,
        EV_FWD_RD    = 4'd5,
        EV_FWD_WR    = 4'd6,
        EV_FWD_FETCH = 4'd7,
        EV_DATA      = 4'd8,
        EV_DATA_X    = 4'd9,
        EV_ACK       = 4'd10,
        EV_WB_ACK    = 4'd11
    } ev_e;

    typedef enum logic [2:0] {
        RQ_GETS = 3'd0,
        RQ_GETI = 3'd1,
        RQ_GETX = 3'd2,
        RQ_UPG  = 3'd3,
        RQ_PUTX = 3'd4
    } rq_e;

    typedef enum logic [1:0] {
        HK_LOAD  = 2'd0,
        HK_FETCH = 2'd1,
        HK_STORE = 2'd2
    } hk_e;

    // One cycle's worth of outgoing strobes
    typedef struct packed {
        logic req;
        rq_e  req_kind;
        logic data_req;
        logic data_l2;
        logic ack;
        logic unblk;
        logic unblk_x;
        logic hit;
        hk_e  hit_kind;
        logic sc_lost;
        logic wake;
        logic stall;
    } act_t;

    // Permission seen by the core for a given state
    function automatic logic [1:0] perm_of(line_st_e s);
        case (s)
            ST_NP, ST_I:        perm_of = 2'b00;
            ST_S, ST_E, ST_SM:  perm_of = 2'b01;
            ST_M:               perm_of = 2'b11;
            default:            perm_of = 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/mesi_l1_decide.sv
// Next-state and action decision for one line and one event.
// Purely combinational. Assumes the caller applies the result only when an
// event is valid and not stalled. The ack count is signed so that acks
// arriving ahead of the data drive it negative.
module mesi_l1_decide
    import mesi_l1_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  ev_e                    ev,
    input  line_st_e               st,
    input  logic                   dirty,
    input  hk_e                    pkind,
    input  logic signed [CNT_W:0]  pend,
    input  logic [CNT_W-1:0]       cnt,
    output act_t                   act,
    output line_st_e               st_nx,
    output logic                   dirty_nx,
    output hk_e                    pkind_nx,
    output logic signed [CNT_W:0]  pend_nx
);

    logic signed [CNT_W:0] sum_data;
    logic signed [CNT_W:0] sum_ack;
    logic                  demand;
    logic                  busy;
    logic                  finish;

    // Count arithmetic for the two ways a write miss can progress
    always_comb begin
        sum_data = pend + $signed({1'b0, cnt});
        sum_ack  = pend - $signed((CNT_W+1)'(1));
    end

    // Classification of the event against the line's state
    always_comb begin
        demand = (ev == EV_LOAD) || (ev == EV_FETCH) || (ev == EV_STORE) || (ev == EV_EVICT);
        busy   = (st == ST_IS) || (st == ST_IM) || (st == ST_SM) || (st == ST_IS_I) ||
                 (st == ST_M_I) || (st == ST_SINK);
    end

    // Transition table
    always_comb begin
        act      = '0;
        st_nx    = st;
        dirty_nx = dirty;
        pkind_nx = pkind;
        pend_nx  = pend;
        finish   = 1'b0;
        if (demand && busy) begin
            act.stall = 1'b1;
        end else begin
            case (st)
                ST_NP, ST_I: begin
                    case (ev)
                        EV_LOAD: begin
                            act.req = 1'b1; act.req_kind = RQ_GETS;
                            st_nx = ST_IS; pkind_nx = HK_LOAD;
                        end
                        EV_FETCH: begin
                            act.req = 1'b1; act.req_kind = RQ_GETI;
                            st_nx = ST_IS; pkind_nx = HK_FETCH;
                        end
                        EV_STORE: begin
                            act.req = 1'b1; act.req_kind = RQ_GETX;
                            st_nx = ST_IM; pkind_nx = HK_STORE; pend_nx = '0;
                        end
                        EV_EVICT: st_nx = ST_NP;
                        EV_INV:   act.ack = 1'b1;
                        default: ;
                    endcase
                end
                ST_S: begin
                    case (ev)
                        EV_LOAD:  begin act.hit = 1'b1; act.hit_kind = HK_LOAD;  end
                        EV_FETCH: begin act.hit = 1'b1; act.hit_kind = HK_FETCH; end
                        EV_STORE: begin
                            act.req = 1'b1; act.req_kind = RQ_UPG;
                            st_nx = ST_SM; pkind_nx = HK_STORE; pend_nx = '0;
                        end
                        EV_EVICT: st_nx = ST_I;
                        EV_INV:   begin act.ack = 1'b1; st_nx = ST_I; end
                        default: ;
                    endcase
                end
                ST_E, ST_M: begin
                    case (ev)
                        EV_LOAD:  begin act.hit = 1'b1; act.hit_kind = HK_LOAD;  end
                        EV_FETCH: begin act.hit = 1'b1; act.hit_kind = HK_FETCH; end
                        EV_STORE: begin
                            act.hit = 1'b1; act.hit_kind = HK_STORE;
                            st_nx = ST_M; dirty_nx = 1'b1;
                        end
                        EV_EVICT: begin
                            act.req = 1'b1; act.req_kind = RQ_PUTX; st_nx = ST_M_I;
                        end
                        EV_INV: begin
                            if (st == ST_M) act.data_l2 = 1'b1;
                            else            act.ack     = 1'b1;
                            st_nx = ST_I;
                        end
                        EV_FWD_RD, EV_FWD_FETCH: begin
                            act.data_req = 1'b1; act.data_l2 = 1'b1; st_nx = ST_S;
                        end
                        EV_FWD_WR: begin
                            act.data_req = 1'b1; st_nx = ST_I;
                        end
                        default: ;
                    endcase
                end
                ST_IS, ST_IS_I: begin
                    case (ev)
                        EV_INV: begin act.ack = 1'b1; st_nx = ST_IS_I; end
                        EV_DATA: begin
                            act.hit = 1'b1; act.hit_kind = pkind;
                            act.unblk = 1'b1; act.wake = 1'b1;
                            st_nx = (st == ST_IS) ? ST_S : ST_I;
                        end
                        EV_DATA_X: begin
                            act.hit = 1'b1; act.hit_kind = pkind;
                            act.unblk_x = 1'b1; act.wake = 1'b1;
                            st_nx = ST_E;
                        end
                        default: ;
                    endcase
                end
                ST_IM, ST_SM: begin
                    case (ev)
                        EV_DATA: begin
                            if (sum_data == '0) finish = 1'b1;
                            else                pend_nx = sum_data;
                        end
                        EV_ACK: begin
                            if (sum_ack == '0) finish = 1'b1;
                            else               pend_nx = sum_ack;
                        end
                        EV_DATA_X: finish = 1'b1;
                        EV_INV: begin
                            act.ack = 1'b1;
                            if (st == ST_SM) begin
                                act.sc_lost = 1'b1; st_nx = ST_IM;
                            end
                        end
                        default: ;
                    endcase
                    if (finish) begin
                        act.hit = 1'b1; act.hit_kind = HK_STORE;
                        act.unblk_x = 1'b1; act.wake = 1'b1;
                        st_nx = ST_M; dirty_nx = 1'b1; pend_nx = '0;
                    end
                end
                ST_M_I, ST_SINK: begin
                    case (ev)
                        EV_WB_ACK: begin act.wake = 1'b1; st_nx = ST_I; end
                        EV_INV: begin
                            if (st == ST_M_I) begin
                                act.data_l2 = 1'b1; st_nx = ST_SINK;
                            end else begin
                                act.ack = 1'b1;
                            end
                        end
                        EV_FWD_RD, EV_FWD_FETCH: begin
                            if (st == ST_M_I) begin
                                act.data_req = 1'b1; act.data_l2 = 1'b1; st_nx = ST_SINK;
                            end
                        end
                        EV_FWD_WR: begin
                            if (st == ST_M_I) begin
                                act.data_req = 1'b1; st_nx = ST_SINK;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
            if (!((st_nx == ST_M) || (st_nx == ST_M_I) || (st_nx == ST_SINK)))
                dirty_nx = 1'b0;
        end
    end

endmodule

// File: rtl/mesi_l1_line_bank.sv
// Per-line storage of state, dirty bit, waiting access kind and ack count.
// Assumes at most one line is written per cycle. Offers one read port for
// the event path and one for the lookup path.
module mesi_l1_line_bank
    import mesi_l1_pkg::*;
#(
    parameter  int LINES = 8,
    parameter  int CNT_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  line_st_e               wr_st,
    input  logic                   wr_dirty,
    input  hk_e                    wr_pkind,
    input  logic signed [CNT_W:0]  wr_pend,
    input  logic [IDX_W-1:0]       rd_idx,
    output line_st_e               rd_st,
    output logic                   rd_dirty,
    output hk_e                    rd_pkind,
    output logic signed [CNT_W:0]  rd_pend,
    input  logic [IDX_W-1:0]       lk_idx,
    output line_st_e               lk_st,
    output logic                   lk_dirty
);

    line_st_e              st_a    [LINES];
    logic                  dirty_a [LINES];
    hk_e                   pkind_a [LINES];
    logic signed [CNT_W:0] pend_a  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_e              st_r;
        logic                  dirty_r;
        hk_e                   pkind_r;
        logic signed [CNT_W:0] pend_r;

        // Hold this line's record; reset to not-present
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r    <= ST_NP;
                dirty_r <= 1'b0;
                pkind_r <= HK_LOAD;
                pend_r  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_r    <= wr_st;
                dirty_r <= wr_dirty;
                pkind_r <= wr_pkind;
                pend_r  <= wr_pend;
            end
        end

        assign st_a[g]    = st_r;
        assign dirty_a[g] = dirty_r;
        assign pkind_a[g] = pkind_r;
        assign pend_a[g]  = pend_r;
    end

    // Read ports
    always_comb begin
        rd_st    = st_a[rd_idx];
        rd_dirty = dirty_a[rd_idx];
        rd_pkind = pkind_a[rd_idx];
        rd_pend  = pend_a[rd_idx];
        lk_st    = st_a[lk_idx];
        lk_dirty = dirty_a[lk_idx];
    end

    // R1
    reset_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (lk_st == ST_NP && !lk_dirty));

endmodule

// File: rtl/mesi_l1_msg_reg.sv
// Output stage: registers one cycle of strobes with the line and dirty bit.
// Assumes the action is already gated to zero when no event is present.
module mesi_l1_msg_reg
    import mesi_l1_pkg::*;
#(
    parameter  int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_t             act_i,
    input  logic [IDX_W-1:0] line_i,
    input  logic             dirty_i,
    output act_t             act_q,
    output logic [IDX_W-1:0] line_q,
    output logic             dirty_q
);

    // Capture this cycle's strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            line_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            act_q   <= act_i;
            line_q  <= line_i;
            dirty_q <= dirty_i;
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
// Coherence controller for the lines of a private, directly indexed L1.
// Accepts one decoded event per cycle and applies it to the named line.
// Emits registered strobes one cycle later. Assumes victim choice, data
// storage and message transport are handled around it.
module mesi_line_ctrl
    import mesi_l1_pkg::*;
#(
    parameter  int LINES = 8,
    parameter  int CNT_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [3:0]       ev_code,
    input  logic [IDX_W-1:0] ev_line,
    input  logic [CNT_W-1:0] ev_acks,
    input  logic [IDX_W-1:0] look_line,
    output logic [3:0]       look_state,
    output logic [1:0]       look_perm,
    output logic             look_dirty,
    output logic             req_valid,
    output logic [2:0]       req_kind,
    output logic             data_to_req,
    output logic             data_to_l2,
    output logic             inv_ack,
    output logic             unblock,
    output logic             unblock_excl,
    output logic [IDX_W-1:0] msg_line,
    output logic             msg_dirty,
    output logic             hit_valid,
    output logic [1:0]       hit_kind,
    output logic             resv_lost,
    output logic             wake_valid,
    output logic             stall
);

    line_st_e              cur_st,  nx_st,  lk_st;
    logic                  cur_dty, nx_dty;
    hk_e                   cur_pk,  nx_pk;
    logic signed [CNT_W:0] cur_pd,  nx_pd;
    act_t                  act, act_g, act_q;
    logic                  wr_en;

    mesi_l1_line_bank #(.LINES(LINES), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (ev_line),
        .wr_st    (nx_st),
        .wr_dirty (nx_dty),
        .wr_pkind (nx_pk),
        .wr_pend  (nx_pd),
        .rd_idx   (ev_line),
        .rd_st    (cur_st),
        .rd_dirty (cur_dty),
        .rd_pkind (cur_pk),
        .rd_pend  (cur_pd),
        .lk_idx   (look_line),
        .lk_st    (lk_st),
        .lk_dirty (look_dirty)
    );

    mesi_l1_decide #(.CNT_W(CNT_W)) u_decide (
        .ev       (ev_e'(ev_code)),
        .st       (cur_st),
        .dirty    (cur_dty),
        .pkind    (cur_pk),
        .pend     (cur_pd),
        .cnt      (ev_acks),
        .act      (act),
        .st_nx    (nx_st),
        .dirty_nx (nx_dty),
        .pkind_nx (nx_pk),
        .pend_nx  (nx_pd)
    );

    // Commit the line update unless the event was refused
    always_comb begin
        wr_en = ev_valid && !act.stall;
        act_g = ev_valid ? act : '0;
    end

    mesi_l1_msg_reg #(.LINES(LINES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_g),
        .line_i  (ev_line),
        .dirty_i (cur_dty),
        .act_q   (act_q),
        .line_q  (msg_line),
        .dirty_q (msg_dirty)
    );

    // Unpack registered strobes and the lookup view onto ports
    always_comb begin
        req_valid    = act_q.req;
        req_kind     = act_q.req_kind;
        data_to_req  = act_q.data_req;
        data_to_l2   = act_q.data_l2;
        inv_ack      = act_q.ack;
        unblock      = act_q.unblk;
        unblock_excl = act_q.unblk_x;
        hit_valid    = act_q.hit;
        hit_kind     = act_q.hit_kind;
        resv_lost    = act_q.sc_lost;
        wake_valid   = act_q.wake;
        stall        = act_q.stall;
        look_state   = lk_st;
        look_perm    = perm_of(lk_st);
    end

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !(req_valid || data_to_req || data_to_l2 || inv_ack ||
                    unblock || unblock_excl || hit_valid || wake_valid));

    // R4
    unblock_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unblock |-> (wake_valid && hit_valid));

    // R5
    excl_unblock_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unblock_excl |-> (wake_valid && hit_valid));

    // R11
    resv_lost_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_lost |-> inv_ack);

    // R9
    l2_data_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_to_l2 |-> !inv_ack);

endmodule

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected result of each cycle,
// and the monitor compares it one time unit after the sampling edge.
module test_mesi_line_ctrl;

    localparam int LN = 8;
    localparam int CW = 4;
    localparam int IW = $clog2(LN);

    localparam int F_REQ = 1, F_DREQ = 2, F_DL2 = 4, F_ACK = 8, F_UNB = 16;
    localparam int F_UNBX = 32, F_HIT = 64, F_SC = 128, F_WAKE = 256, F_STALL = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [3:0]    ev_code = '0;
    logic [IW-1:0] ev_line = '0;
    logic [CW-1:0] ev_acks = '0;
    logic [IW-1:0] look_line = '0;
    logic [3:0]    look_state;
    logic [1:0]    look_perm;
    logic          look_dirty, req_valid, data_to_req, data_to_l2, inv_ack;
    logic          unblock, unblock_excl, msg_dirty, hit_valid, resv_lost;
    logic          wake_valid, stall;
    logic [2:0]    req_kind;
    logic [1:0]    hit_kind;
    logic [IW-1:0] msg_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    fl;
        int    rk;
        int    hk;
        int    st;
        bit    dty;
        int    line;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.LINES(LN), .CNT_W(CW)) i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_line(ev_line), .ev_acks(ev_acks), .look_line(look_line),
        .look_state(look_state), .look_perm(look_perm), .look_dirty(look_dirty),
        .req_valid(req_valid), .req_kind(req_kind), .data_to_req(data_to_req),
        .data_to_l2(data_to_l2), .inv_ack(inv_ack), .unblock(unblock),
        .unblock_excl(unblock_excl), .msg_line(msg_line), .msg_dirty(msg_dirty),
        .hit_valid(hit_valid), .hit_kind(hit_kind), .resv_lost(resv_lost),
        .wake_valid(wake_valid), .stall(stall)
    );

    // Permission expected for a state code (R12)
    function automatic int perm_for(int s);
        if (s == 0 || s == 1) return 0;
        if (s == 2 || s == 3 || s == 7) return 1;
        if (s == 4) return 3;
        return 2;
    endfunction

    // Drive one cycle and queue what it must produce
    task automatic drive(bit v, int ev, int ln, int acks, int fl, int rk, int hk,
                         int st, bit dty, string tag);
        exp_t e;
        @(negedge clk);
        ev_valid  = v;
        ev_code   = 4'(ev);
        ev_line   = IW'(ln);
        ev_acks   = CW'(acks);
        look_line = IW'(ln);
        e.fl = fl; e.rk = rk; e.hk = hk; e.st = st; e.dty = dty;
        e.line = ln; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ev(int code, int ln, int acks, int fl, int rk, int hk,
                      int st, bit dty, string tag);
        drive(1'b1, code, ln, acks, fl, rk, hk, st, dty, tag);
    endtask

    task automatic look(int ln, int st, bit dty, string tag);
        drive(1'b0, 0, ln, 0, 0, 0, 0, st, dty, tag);
    endtask

    // Monitor: compare outputs after each sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                int   act_fl;
                bit   bad;
                e = q.pop_front();
                act_fl = int'({stall, wake_valid, resv_lost, hit_valid, unblock_excl,
                               unblock, inv_ack, data_to_l2, data_to_req, req_valid});
                bad = (act_fl != e.fl) || (int'(look_state) != e.st) ||
                      (look_dirty != e.dty) || (int'(look_perm) != perm_for(e.st));
                if ((e.fl & F_REQ) != 0 && int'(req_kind) != e.rk) bad = 1'b1;
                if ((e.fl & F_HIT) != 0 && int'(hit_kind) != e.hk) bad = 1'b1;
                if (e.fl != 0 && int'(msg_line) != e.line) bad = 1'b1;
                checks++;
                if (bad) begin
                    fails++;
                    $display("FAIL %s: flags=%0h st=%0d perm=%0d dirty=%0d rk=%0d hk=%0d line=%0d expected flags=%0h st=%0d perm=%0d dirty=%0d rk=%0d hk=%0d line=%0d",
                             e.tag, act_fl, look_state, look_perm, look_dirty, req_kind,
                             hit_kind, msg_line, e.fl, e.st, perm_for(e.st), e.dty,
                             e.rk, e.hk, e.line);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        look(0, 0, 0, "R1 reset line 0");
        look(7, 0, 0, "R1 reset line 7");

        // Line 0: read miss, stalls, upgrade, lost reservation, ack counting
        ev(0, 0, 0, F_REQ, 0, 0, 5, 0, "R2 load miss GETS");
        ev(0, 0, 0, F_STALL, 0, 0, 5, 0, "R3 load stalled in IS");
        ev(2, 0, 0, F_STALL, 0, 0, 5, 0, "R3 store stalled in IS");
        ev(8, 0, 0, F_HIT|F_UNB|F_WAKE, 0, 0, 2, 0, "R4 data fills S");
        ev(0, 0, 0, F_HIT, 0, 0, 2, 0, "R6 load hit in S");
        ev(2, 0, 0, F_REQ, 3, 0, 7, 0, "R2 store in S UPGRADE");
        ev(4, 0, 0, F_ACK|F_SC, 0, 0, 6, 0, "R11 inv in SM to IM");
        ev(8, 0, 2, 0, 0, 0, 6, 0, "R5 data owes two acks");
        ev(10, 0, 0, 0, 0, 0, 6, 0, "R5 first ack");
        ev(10, 0, 0, F_HIT|F_UNBX|F_WAKE, 0, 2, 4, 1, "R5 last ack to M");

        // Line 1: fetch race with invalidate, exclusive fill, forwarded read
        ev(1, 1, 0, F_REQ, 1, 0, 5, 0, "R2 fetch miss GET_INSTR");
        ev(4, 1, 0, F_ACK, 0, 0, 8, 0, "R10 inv in IS");
        ev(8, 1, 0, F_HIT|F_UNB|F_WAKE, 0, 1, 1, 0, "R10 data after inv ends I");
        ev(0, 1, 0, F_REQ, 0, 0, 5, 0, "R2 load miss from I");
        ev(9, 1, 0, F_HIT|F_UNBX|F_WAKE, 0, 0, 3, 0, "R4 exclusive data to E");
        ev(2, 1, 0, F_HIT, 0, 2, 4, 1, "R6 store hit E to M");
        ev(5, 1, 0, F_DREQ|F_DL2, 0, 0, 2, 0, "R9 fwd read in M");
        ev(3, 1, 0, 0, 0, 0, 1, 0, "R7 silent evict from S");

        // Line 2: acks before data, forwarded write, writeback
        ev(2, 2, 0, F_REQ, 2, 0, 6, 0, "R2 store miss GETX");
        ev(10, 2, 0, 0, 0, 0, 6, 0, "R5 ack before data");
        ev(8, 2, 1, F_HIT|F_UNBX|F_WAKE, 0, 2, 4, 1, "R5 data completes M");
        ev(6, 2, 0, F_DREQ, 0, 0, 1, 0, "R9 fwd write in M");
        ev(2, 2, 0, F_REQ, 2, 0, 6, 0, "R2 store miss again");
        ev(9, 2, 0, F_HIT|F_UNBX|F_WAKE, 0, 2, 4, 1, "R5 exclusive data completes");
        ev(3, 2, 0, F_REQ, 4, 0, 9, 1, "R7 evict M PUTX");
        ev(0, 2, 0, F_STALL, 0, 0, 9, 1, "R3 load stalled in M_I");
        ev(11, 2, 0, F_WAKE, 0, 0, 1, 0, "R7 writeback ack");

        // Line 3: invalidate in M, writeback races into SINK
        ev(2, 3, 0, F_REQ, 2, 0, 6, 0, "R2 store miss line 3");
        ev(8, 3, 0, F_HIT|F_UNBX|F_WAKE, 0, 2, 4, 1, "R5 data no acks");
        ev(4, 3, 0, F_DL2, 0, 0, 1, 0, "R11 inv in M sends data");
        ev(0, 3, 0, F_REQ, 0, 0, 5, 0, "R2 load miss line 3");
        ev(9, 3, 0, F_HIT|F_UNBX|F_WAKE, 0, 0, 3, 0, "R4 exclusive data line 3");
        ev(3, 3, 0, F_REQ, 4, 0, 9, 0, "R7 evict E PUTX");
        ev(4, 3, 0, F_DL2, 0, 0, 10, 0, "R8 inv in M_I");
        ev(4, 3, 0, F_ACK, 0, 0, 10, 0, "R8 inv in SINK");
        ev(11, 3, 0, F_WAKE, 0, 0, 1, 0, "R8 writeback ack in SINK");

        // Line 4: forwarded write during writeback
        ev(0, 4, 0, F_REQ, 0, 0, 5, 0, "R2 load miss line 4");
        ev(9, 4, 0, F_HIT|F_UNBX|F_WAKE, 0, 0, 3, 0, "R4 exclusive line 4");
        ev(3, 4, 0, F_REQ, 4, 0, 9, 0, "R7 evict line 4");
        ev(6, 4, 0, F_DREQ, 0, 0, 10, 0, "R8 fwd write in M_I");
        ev(11, 4, 0, F_WAKE, 0, 0, 1, 0, "R8 writeback ack line 4");

        // Line 5: invalidate in E
        ev(0, 5, 0, F_REQ, 0, 0, 5, 0, "R2 load miss line 5");
        ev(9, 5, 0, F_HIT|F_UNBX|F_WAKE, 0, 0, 3, 0, "R4 exclusive line 5");
        ev(4, 5, 0, F_ACK, 0, 0, 1, 0, "R11 inv in E");

        // Line 6: events on a line never fetched
        ev(4, 6, 0, F_ACK, 0, 0, 0, 0, "R11 inv in NP");
        ev(3, 6, 0, 0, 0, 0, 0, 0, "R7 evict in NP");

        // Isolation: earlier lines unchanged
        look(0, 4, 1, "R13 line 0 still M");
        look(7, 0, 0, "R13 line 7 untouched");
        look(2, 1, 0, "R12 line 2 in I");

        @(negedge clk);
        ev_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule